// File: doc/BRIEF.md
# Serial Port with Packed Line Control

This block is an asynchronous serial port that a processor reaches through two memory-mapped registers. Through the data register, software queues characters for transmission and collects received characters. Every received character comes back with its own error flags, so a framing, parity or overrun fault stays with the character it belongs to. A single line-control word holds the whole frame setup: rate divisor, character size, parity, stop bits, FIFO use and a forced-break request.

A free-running baud generator makes a tick at sixteen times the bit rate. The transmitter and the receiver both work from that tick. Each direction is buffered by a 16-entry FIFO, and clearing the FIFO-enable bit cuts each one down to a single holding slot. The bus side is plain register access with one-cycle strobes. Back-pressure on the transmit path is given by `tx_full`: while `tx_full` is high, a write to the data register is dropped. On the receive side, `rx_empty` shows whether a read returns a character. Reading the data register while the receive queue is not empty takes the character out of the queue.

Top module: `uart_lcr_port`

## Requirements
- R1: After reset, `txd` is 1, `rx_empty` is 1, `tx_full` is 0, `busy` is 0, and the line-control register reads as 0.
- R2: Byte address 0x00 selects the data register and byte address 0x40 selects the line-control register. The line-control register reads back bits 18:0 as written and reads 0 above them. A read of the data register while the receive queue is empty returns 0.
- R3: Line-control bits 18:17 set the character size: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bit 15 set selects two stop bits. Data goes out LSB first after one low start bit. A received character appears right-aligned in read bits 7:0, with zeros above the character size.
- R4: With a divisor N in line-control bits 11:0, every bit on `txd` lasts exactly 16*(N+1) clock cycles.
- R5: Line-control bit 13 enables a parity bit after the data. Bit 14 set selects even parity, and clear selects odd. When a received parity bit does not match, read bit 9 of that character is set.
- R6: A start bit is accepted only if the line is still low at the middle of the start bit, so a shorter low pulse stores nothing. If the first stop bit is sampled low, read bit 8 of that character is set.
- R7: If a character completes while the receive queue is full, that character is discarded and read bit 10 is set on the newest stored entry.
- R8: With line-control bit 16 set, each queue holds 16 characters. With bit 16 clear, each queue holds 1. `tx_full` is high when the transmit queue is at its limit, and any data write made while it is high is dropped.
- R9: `busy` is high while the transmit queue holds a character or a frame is being shifted out.
- R10: While line-control bit 12 is set, `txd` is held low.
- R11: While `port_en` is low, `txd` stays high, queued characters are not sent, and the line at `rxd` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_en | input | 1 | Enables the transmitter and the receiver |
| bus_we | input | 1 | One-cycle register write strobe |
| bus_re | input | 1 | One-cycle register read strobe (takes a character out of the receive queue) |
| bus_addr | input | 7 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output, registered |
| rx_empty | output | 1 | Receive queue holds no character |
| tx_full | output | 1 | Transmit queue is at its limit |
| busy | output | 1 | Transmission still in progress |

## Verification
The bench loops the port back on itself and runs one frame format after another. It changes the character size, parity sense, stop-bit count and divisor, so a receiver that shifts the wrong way or misaligns short characters returns corrupted values. It also drives hand-made frames with a wrong parity bit, a low stop bit and a short glitch. A design that checks parity with the wrong sense, never samples the stop bit, or starts on any falling edge then returns wrong flags or stores characters that should not exist. It also fills the receive queue, with and without the FIFO enabled, to catch an overrun that overwrites data or loses its flag. Finally, it measures the start-bit width, holds the port disabled with characters queued, and requests a break.

// File: rtl/uart_lcr_pkg.sv
package uart_lcr_pkg;
  localparam int unsigned ADDR_W  = 7;
  localparam logic [ADDR_W-1:0] REG_DATA = 7'h00;
  localparam logic [ADDR_W-1:0] REG_LCR  = 7'h40;
  localparam int unsigned LCR_W   = 19;
  localparam int unsigned RXW_W   = 11;

  // field positions are software-visible; order matters
  typedef struct packed {
    logic [1:0]  wlen;
    logic        fifo_en;
    logic        two_stop;
    logic        even;
    logic        par_en;
    logic        brk;
    logic [11:0] div;
  } lcr_t;

  typedef enum logic [2:0] {FS_IDLE, FS_START, FS_DATA, FS_PAR, FS_STOP} frame_st_e;

  function automatic logic [7:0] word_mask(input logic [1:0] wl);
    return 8'hFF >> (2'd3 - wl);
  endfunction

  function automatic logic [2:0] last_bit(input logic [1:0] wl);
    return 3'd4 + {1'b0, wl};
  endfunction
endpackage

// File: rtl/uart_lcr_baud.sv
module uart_lcr_baud #(
  parameter int unsigned DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = en && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!en)         cnt <= '0;
    else if (cnt >= div)  cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uart_lcr_fifo.sv
module uart_lcr_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         deep,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  input  logic         mark,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full,
  output logic [$clog2(DEPTH):0] level
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   limit;
  logic          do_push, do_pop;

  assign limit   = deep ? (AW+1)'(DEPTH) : (AW+1)'(1);
  assign full    = level >= limit;
  assign empty   = level == '0;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
    if (mark && !empty) mem[AW'(wp - 1'b1)][W-1] <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; level <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/uart_lcr_tx.sv
module uart_lcr_tx
  import uart_lcr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  lcr_t       cfg,
  input  logic       q_empty,
  input  logic [7:0] q_data,
  output logic       q_pop,
  output logic       line,
  output logic       active
);
  frame_st_e  st;
  logic [3:0] sub;
  logic [2:0] bitn;
  logic [7:0] sh, masked;
  logic       pbit;

  assign masked = q_data & word_mask(cfg.wlen);
  assign q_pop  = en && tick && (st == FS_IDLE) && !q_empty;
  assign active = st != FS_IDLE;

  always_comb begin
    case (st)
      FS_START: line = 1'b0;
      FS_DATA:  line = sh[0];
      FS_PAR:   line = pbit;
      default:  line = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= FS_IDLE; sub <= '0; bitn <= '0; sh <= '0; pbit <= 1'b0;
    end else if (!en) begin
      st <= FS_IDLE;
    end else if (st == FS_IDLE) begin
      if (q_pop) begin
        st   <= FS_START;
        sub  <= '0;
        sh   <= masked;
        pbit <= cfg.even ? ^masked : ~^masked;
      end
    end else if (tick) begin
      sub <= sub + 4'd1;
      if (sub == 4'd15) begin
        case (st)
          FS_START: begin st <= FS_DATA; bitn <= '0; end
          FS_DATA: begin
            sh <= sh >> 1;
            if (bitn == last_bit(cfg.wlen)) begin
              st   <= cfg.par_en ? FS_PAR : FS_STOP;
              bitn <= '0;
            end else begin
              bitn <= bitn + 3'd1;
            end
          end
          FS_PAR: begin st <= FS_STOP; bitn <= '0; end
          FS_STOP: begin
            if (cfg.two_stop && bitn == 3'd0) bitn <= 3'd1;
            else st <= FS_IDLE;
          end
          default: st <= FS_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_lcr_rx.sv
module uart_lcr_rx
  import uart_lcr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  lcr_t       cfg,
  input  logic       rxd,
  output logic       done,
  output logic [7:0] data,
  output logic       ferr,
  output logic       perr
);
  frame_st_e  st;
  logic [3:0] sub;
  logic [2:0] bitn;
  logic [7:0] sh;
  logic       acc;
  logic       s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; s3 <= 1'b1;
    end else begin
      s1 <= rxd; s2 <= s1; s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= FS_IDLE; sub <= '0; bitn <= '0; sh <= '0; acc <= 1'b0;
      done <= 1'b0; data <= '0; ferr <= 1'b0; perr <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        st <= FS_IDLE;
      end else begin
        case (st)
          FS_IDLE: if (s3 && !s2) begin st <= FS_START; sub <= '0; end
          FS_START: if (tick) begin
            sub <= sub + 4'd1;
            if (sub == 4'd7) begin
              if (!s2) begin
                st <= FS_DATA; sub <= '0; bitn <= '0; acc <= 1'b0; perr <= 1'b0;
              end else begin
                st <= FS_IDLE;
              end
            end
          end
          FS_DATA: if (tick) begin
            sub <= sub + 4'd1;
            if (sub == 4'd15) begin
              sh  <= {s2, sh[7:1]};
              acc <= acc ^ s2;
              if (bitn == last_bit(cfg.wlen)) st <= cfg.par_en ? FS_PAR : FS_STOP;
              else bitn <= bitn + 3'd1;
            end
          end
          FS_PAR: if (tick) begin
            sub <= sub + 4'd1;
            if (sub == 4'd15) begin
              perr <= s2 != (cfg.even ? acc : ~acc);
              st   <= FS_STOP;
            end
          end
          FS_STOP: if (tick) begin
            sub <= sub + 4'd1;
            if (sub == 4'd15) begin
              done <= 1'b1;
              ferr <= !s2;
              data <= sh >> (3'd7 - last_bit(cfg.wlen));
              st   <= FS_IDLE;
            end
          end
          default: st <= FS_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_lcr_port.sv
module uart_lcr_port
  import uart_lcr_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              rxd,
  output logic              txd,
  output logic              rx_empty,
  output logic              tx_full,
  output logic              busy
);
  localparam int unsigned LW = $clog2(FIFO_DEPTH) + 1;

  lcr_t             lcr_q;
  logic             tick, tx_push, tx_pop, tx_empty, tx_line, tx_active;
  logic [7:0]       tx_dout;
  logic [LW-1:0]    tx_level, rx_level;
  logic             rx_pop, rx_full_w, rx_done, rx_ferr, rx_perr;
  logic [7:0]       rx_data;
  logic [RXW_W-1:0] rx_dout;

  assign tx_push = bus_we && (bus_addr == REG_DATA);
  assign rx_pop  = bus_re && (bus_addr == REG_DATA);
  assign busy    = !tx_empty || tx_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lcr_q <= '0;
    else if (bus_we && bus_addr == REG_LCR) lcr_q <= lcr_t'(bus_wdata[LCR_W-1:0]);
  end

  always_comb begin
    if (bus_addr == REG_LCR)                   bus_rdata = 32'(lcr_q);
    else if (bus_addr == REG_DATA && !rx_empty) bus_rdata = 32'(rx_dout);
    else                                        bus_rdata = '0;
  end

  uart_lcr_baud #(.DIV_W(12)) u_baud (
    .clk(clk), .rst_n(rst_n), .en(port_en), .div(lcr_q.div), .tick(tick)
  );

  uart_lcr_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .deep(lcr_q.fifo_en), .push(tx_push),
    .din(bus_wdata[7:0]), .pop(tx_pop), .mark(1'b0), .dout(tx_dout),
    .empty(tx_empty), .full(tx_full), .level(tx_level)
  );

  uart_lcr_tx u_tx (
    .clk(clk), .rst_n(rst_n), .en(port_en), .tick(tick), .cfg(lcr_q),
    .q_empty(tx_empty), .q_data(tx_dout), .q_pop(tx_pop),
    .line(tx_line), .active(tx_active)
  );

  uart_lcr_rx u_rx (
    .clk(clk), .rst_n(rst_n), .en(port_en), .tick(tick), .cfg(lcr_q),
    .rxd(rxd), .done(rx_done), .data(rx_data), .ferr(rx_ferr), .perr(rx_perr)
  );

  uart_lcr_fifo #(.W(RXW_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .deep(lcr_q.fifo_en),
    .push(rx_done && !rx_full_w), .din({1'b0, rx_perr, rx_ferr, rx_data}),
    .pop(rx_pop), .mark(rx_done && rx_full_w), .dout(rx_dout),
    .empty(rx_empty), .full(rx_full_w), .level(rx_level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          txd <= 1'b1;
    else if (lcr_q.brk)  txd <= 1'b0;
    else if (!port_en)   txd <= 1'b1;
    else                 txd <= tx_line;
  end
endmodule

// File: rtl/uart_lcr_chk.sv
module uart_lcr_chk #(
  parameter int unsigned DEPTH = 16
) (
  input logic clk,
  input logic rst_n,
  input logic port_en,
  input logic brk,
  input logic txd,
  input logic tx_full,
  input logic busy,
  input logic rx_full,
  input logic rx_pop,
  input logic [$clog2(DEPTH):0] rx_level
);
  // R10
  brk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk && $past(brk) |-> !txd);

  // R11
  off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en && $past(!port_en) && !brk && $past(!brk) |-> txd);

  // R9
  full_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> busy);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= ($clog2(DEPTH)+1)'(DEPTH));

  // R7
  ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full && !rx_pop |=> rx_level == $past(rx_level));
endmodule

bind uart_lcr_port uart_lcr_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .port_en(port_en), .brk(lcr_q.brk), .txd(txd),
  .tx_full(tx_full), .busy(busy), .rx_full(rx_full_w), .rx_pop(rx_pop),
  .rx_level(rx_level)
);

// File: tb/tb_uart_lcr_port.sv
module tb_uart_lcr_port;
  logic clk = 0, rst_n = 0, port_en = 0;
  logic bus_we = 0, bus_re = 0;
  logic [6:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic txd, rx_empty, tx_full, busy;
  logic loop = 1, bb = 1;
  logic rxd;
  int total = 0, bad = 0;

  assign rxd = loop ? txd : bb;
  always #5 clk = ~clk;

  uart_lcr_port dut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rxd(rxd), .txd(txd), .rx_empty(rx_empty), .tx_full(tx_full), .busy(busy)
  );

  localparam logic [18:0] VL [6] = '{19'h70000, 19'h56001, 19'h3A002, 19'h00000, 19'h7E003, 19'h62000};
  localparam logic [7:0]  VD [6] = '{8'hA5, 8'hD3, 8'h7F, 8'hFF, 8'h81, 8'h00};
  localparam logic [10:0] VE [6] = '{11'h0A5, 11'h053, 11'h03F, 11'h01F, 11'h081, 11'h000};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_re = 1; #1 d = bus_rdata;
    @(negedge clk); bus_re = 0;
  endtask

  task automatic wait_rx();
    for (int i = 0; i < 20000 && rx_empty; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    repeat (200) @(negedge clk);
  endtask

  task automatic bang(input logic [7:0] d, input int nb, input logic pen,
                      input logic pb, input logic sv);
    bb = 0; repeat (16) @(negedge clk);
    for (int i = 0; i < nb; i++) begin bb = d[i]; repeat (16) @(negedge clk); end
    if (pen) begin bb = pb; repeat (16) @(negedge clk); end
    bb = sv; repeat (16) @(negedge clk);
    bb = 1;  repeat (40) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int n, errs;
    repeat (5) @(negedge clk);
    rst_n = 1; port_en = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 txd", txd, 1); chk("R1 rx_empty", rx_empty, 1);
    chk("R1 tx_full", tx_full, 0); chk("R1 busy", busy, 0);
    rd(7'h40, r); chk("R1 lcr", r, 0);

    // R2 register map
    wr(7'h40, 32'hFFFE_003);
    rd(7'h40, r); chk("R2 lcr readback", r, 32'h7E003);
    rd(7'h00, r); chk("R2 empty data read", r, 0);

    // R3 R5 table of frame formats through loopback
    for (int v = 0; v < 6; v++) begin
      wr(7'h40, 32'(VL[v]));
      wr(7'h00, 32'(VD[v]));
      wait_rx();
      rd(7'h00, r);
      chk($sformatf("R3 vector %0d", v), r, 32'(VE[v]));
      wait_idle();
    end

    // R4 bit time with N=2
    wr(7'h40, 32'h70002);
    wr(7'h00, 32'hFF);
    while (txd) @(negedge clk);
    n = 0;
    while (!txd) begin n++; @(negedge clk); end
    chk("R4 start bit cycles", n, 48);
    wait_rx(); rd(7'h00, r); chk("R4 char", r, 32'hFF);
    wait_idle();

    // R9 busy
    wr(7'h40, 32'h70000);
    wr(7'h00, 32'h5A);
    chk("R9 busy while sending", busy, 1);
    wait_idle();
    chk("R9 busy cleared", busy, 0);
    rd(7'h00, r); chk("R9 char", r, 32'h5A);

    // R6 framing error, R5 parity error, R6 glitch rejection
    loop = 0;
    bang(8'h3C, 8, 0, 0, 0);
    rd(7'h00, r); chk("R6 framing flag", r, 32'h13C);
    wr(7'h40, 32'h76000);
    bang(8'h01, 8, 1, 0, 1);
    rd(7'h00, r); chk("R5 parity flag", r, 32'h201);
    bb = 0; repeat (3) @(negedge clk); bb = 1; repeat (300) @(negedge clk);
    chk("R6 glitch ignored", rx_empty, 1);

    // R7 overrun with single-slot queue
    wr(7'h40, 32'h60000);
    bang(8'h11, 8, 0, 0, 1);
    bang(8'h22, 8, 0, 0, 1);
    rd(7'h00, r); chk("R7 overrun marked", r, 32'h411);
    chk("R7 second dropped", rx_empty, 1);

    // R11 receiver ignores the line while disabled
    port_en = 0;
    bang(8'h55, 8, 0, 0, 1);
    chk("R11 rx ignored", rx_empty, 1);

    // R8 depth 16, R11 transmitter held
    loop = 1;
    wr(7'h40, 32'h70000);
    for (int i = 0; i < 16; i++) wr(7'h00, 32'(i));
    chk("R8 tx_full at 16", tx_full, 1);
    wr(7'h00, 32'hEE);
    repeat (300) @(negedge clk);
    chk("R11 txd idle", txd, 1);
    port_en = 1;
    wait_idle();
    errs = 0;
    for (int i = 0; i < 16; i++) begin
      rd(7'h00, r);
      if (r !== 32'(i)) errs++;
    end
    chk("R8 sixteen chars in order", errs, 0);
    chk("R8 seventeenth dropped", rx_empty, 1);

    // R8 single holding slot
    port_en = 0;
    wr(7'h40, 32'h60000);
    wr(7'h00, 32'h42);
    chk("R8 single slot full", tx_full, 1);
    port_en = 1;
    wait_idle();
    rd(7'h00, r); chk("R8 single slot char", r, 32'h42);

    // R10 break
    loop = 0;
    wr(7'h40, 32'h71000);
    repeat (3) @(negedge clk);
    chk("R10 break low", txd, 0);
    wr(7'h40, 32'h70000);
    repeat (3) @(negedge clk);
    chk("R10 break released", txd, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule